// File: doc/BRIEF.md
# Video Stream Protocol Repairer

This block sits on a packetised video stream carrying one pixel per beat, with valid/ready flow control and start/end-of-packet markers. It reads the type code on each packet's first beat. Video data packets are forced to the frame size held in two configuration registers. A packet that ends early is padded out to a full frame. A packet that runs long is cut at the frame size, and the rest of it is swallowed. Packets of every other type go through untouched.

Place it ahead of any stage that cannot tolerate malformed frames. Software, or a neighbouring block, writes the expected width and height through a small write-only register port. Short idle gaps are inserted after each line and after each frame, so the stages downstream see regular line and frame boundaries.

Top module: `vstream_mend`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `out_valid` is low and `in_ready` is high.
- R2: The type code is `in_data[3:0]` on a beat with `in_sop` high, and code 0 marks a video packet. A video header is forwarded with `out_sop` high and `out_eop` low, even when the input header carries `in_eop`.
- R3: A video packet of exactly width×height pixels is forwarded pixel for pixel in raster order, with `out_eop` high on pixel width×height and on no other pixel.
- R4: When a video packet ends before width×height pixels, `in_ready` drops in the cycle after the end beat is accepted. The output then repeats the last accepted pixel until the frame is full, or repeats zero when the header itself ended the packet. `out_eop` marks the final pixel.
- R5: When a video packet runs past width×height pixels, pixel width×height is emitted with `out_eop` forced high. All later input beats up to and including the end beat are accepted and produce no output.
- R6: A packet with any other type code (1 to 15) is forwarded beat for beat with its own sop/eop flags. When neither side stalls, no idle cycles are inserted between its beats.
- R7: With the source always ready and `out_ready` held high, exactly LINE_GAP idle output cycles separate the last pixel of one line from the first pixel of the next.
- R8: With `out_ready` held high and the next packet waiting at the input, exactly FRAME_GAP idle output cycles separate a video packet's end beat from the next header.
- R9: While `out_valid` is high and `out_ready` is low, the output beat (valid, data, sop, eop) holds unchanged.
- R10: A write with `cfg_addr`=0 sets the width and `cfg_addr`=1 sets the height. A written 0 is stored as 1. New values apply from the next video header: a frame already in progress keeps its size.
- R11: Beats that arrive without `in_sop` while no packet is open are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects width, 1 selects height |
| cfg_wdata | input | CW | Value written |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle when high with in_valid |
| in_data | input | DW | Input beat payload; bits 3:0 carry the type code on a start beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| out_valid | output | 1 | Output beat valid (registered) |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DW | Output beat payload |
| out_sop | output | 1 | First beat of an output packet |
| out_eop | output | 1 | Last beat of an output packet |

## Verification
A beat accepted at a clock edge shows on the registered output from that edge, so the output is sampled at the following falling edge. Each line gap and frame gap starts at the edge that emits the closing pixel, and the next beat appears LINE_GAP+1 or FRAME_GAP+1 cycles after it. The checks compare cycle stamps taken at the falling edges against these distances. The `in_ready` drop during padding is sampled at the first falling edge after the end beat's handshake. Sequence checks wait until the expected number of beats has drained, then wait a further settle window so that extra or missing beats are caught.

// File: rtl/vstream_mend_pkg.sv
package vstream_mend_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_VID,
    ST_PAD,
    ST_DROP
  } mend_state_e;

  localparam logic [3:0] PKT_VIDEO = 4'd0;
endpackage

// File: rtl/vsm_size_regs.sv
module vsm_size_regs #(
  parameter int CW    = 12,
  parameter int DEF_W = 1920,
  parameter int DEF_H = 1080
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          latch,
  output logic [CW-1:0] act_w,
  output logic [CW-1:0] act_h
);
  logic [CW-1:0] pend_w, pend_h, wval;

  assign wval = (cfg_wdata == '0) ? CW'(1) : cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_w <= CW'(DEF_W);
      pend_h <= CW'(DEF_H);
      act_w  <= CW'(DEF_W);
      act_h  <= CW'(DEF_H);
    end else begin
      if (cfg_we && !cfg_addr) pend_w <= wval;
      if (cfg_we &&  cfg_addr) pend_h <= wval;
      if (latch) begin
        act_w <= pend_w;
        act_h <= pend_h;
      end
    end
  end

  // R10
  size_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch |=> ($stable(act_w) && $stable(act_h)));
endmodule

// File: rtl/vsm_raster.sv
module vsm_raster #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  output logic          line_end,
  output logic          frame_end
);
  logic [CW-1:0] col_q, row_q;

  assign line_end  = (col_q == width - CW'(1));
  assign frame_end = line_end && (row_q == height - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      col_q <= '0;
      row_q <= '0;
    end else if (step) begin
      if (line_end) begin
        col_q <= '0;
        row_q <= frame_end ? '0 : row_q + CW'(1);
      end else begin
        col_q <= col_q + CW'(1);
      end
    end
  end

  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    (col_q < width) && (row_q < height));
endmodule

// File: rtl/vsm_gap_timer.sv
module vsm_gap_timer #(
  parameter int GW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [GW-1:0] len,
  output logic          busy
);
  logic [GW-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (start)     cnt_q <= len;
    else if (busy)      cnt_q <= cnt_q - GW'(1);
  end

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/vstream_mend.sv
module vstream_mend
  import vstream_mend_pkg::*;
#(
  parameter int DW        = 24,
  parameter int CW        = 12,
  parameter int DEF_W     = 1920,
  parameter int DEF_H     = 1080,
  parameter int LINE_GAP  = 2,
  parameter int FRAME_GAP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sop,
  input  logic          in_eop,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop
);
  localparam int GMAX = (LINE_GAP > FRAME_GAP) ? LINE_GAP : FRAME_GAP;
  localparam int GW   = $clog2(GMAX + 2);

  mend_state_e   state_q, state_d;
  logic [DW-1:0] last_q, last_d;
  logic          load, gap_busy, gap_start;
  logic [GW-1:0] gap_len;
  logic          latch, cnt_clear, step, line_end, frame_end;
  logic          emit, e_sop, e_eop;
  logic [DW-1:0] e_data;
  logic [CW-1:0] act_w, act_h;

  vsm_size_regs #(.CW(CW), .DEF_W(DEF_W), .DEF_H(DEF_H)) u_size (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .latch(latch), .act_w(act_w), .act_h(act_h)
  );

  vsm_raster #(.CW(CW)) u_raster (
    .clk(clk), .rst(rst), .clear(cnt_clear), .step(step),
    .width(act_w), .height(act_h), .line_end(line_end), .frame_end(frame_end)
  );

  vsm_gap_timer #(.GW(GW)) u_gap (
    .clk(clk), .rst(rst), .start(gap_start), .len(gap_len), .busy(gap_busy)
  );

  assign load = !out_valid || out_ready;

  always_comb begin
    state_d   = state_q;
    last_d    = last_q;
    in_ready  = 1'b0;
    emit      = 1'b0;
    e_data    = in_data;
    e_sop     = 1'b0;
    e_eop     = 1'b0;
    latch     = 1'b0;
    cnt_clear = 1'b0;
    step      = 1'b0;
    gap_start = 1'b0;
    gap_len   = GW'(LINE_GAP);
    if (!gap_busy) begin
      unique case (state_q)
        ST_IDLE: begin
          in_ready = load;
          if (in_valid && load && in_sop) begin
            emit  = 1'b1;
            e_sop = 1'b1;
            if (in_data[3:0] == PKT_VIDEO) begin
              latch     = 1'b1;
              cnt_clear = 1'b1;
              last_d    = '0;
              state_d   = in_eop ? ST_PAD : ST_VID;
            end else begin
              e_eop   = in_eop;
              state_d = in_eop ? ST_IDLE : ST_PASS;
            end
          end
        end
        ST_PASS: begin
          in_ready = load;
          if (in_valid && load) begin
            emit  = 1'b1;
            e_sop = in_sop;
            e_eop = in_eop;
            if (in_eop) state_d = ST_IDLE;
          end
        end
        ST_VID: begin
          in_ready = load;
          if (in_valid && load) begin
            emit   = 1'b1;
            step   = 1'b1;
            e_eop  = frame_end;
            last_d = in_data;
            if (frame_end) begin
              if (in_eop) begin
                gap_start = 1'b1;
                gap_len   = GW'(FRAME_GAP);
                state_d   = ST_IDLE;
              end else begin
                state_d = ST_DROP;
              end
            end else begin
              gap_start = line_end;
              if (in_eop) state_d = ST_PAD;
            end
          end
        end
        ST_PAD: begin
          if (load) begin
            emit   = 1'b1;
            step   = 1'b1;
            e_data = last_q;
            e_eop  = frame_end;
            if (frame_end) begin
              gap_start = 1'b1;
              gap_len   = GW'(FRAME_GAP);
              state_d   = ST_IDLE;
            end else begin
              gap_start = line_end;
            end
          end
        end
        ST_DROP: begin
          in_ready = 1'b1;
          if (in_valid && in_eop) begin
            gap_start = 1'b1;
            gap_len   = GW'(FRAME_GAP);
            state_d   = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      last_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else begin
      state_q <= state_d;
      last_q  <= last_d;
      if (load) begin
        out_valid <= emit;
        if (emit) begin
          out_data <= e_data;
          out_sop  <= e_sop;
          out_eop  <= e_eop;
        end
      end
    end
  end

  // R9
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_sop) && $stable(out_eop)));

  // R7
  gap_stall_chk: assert property (@(posedge clk) disable iff (rst)
    gap_busy |-> !in_ready);

  // R5
  drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DROP && out_ready) |=> !out_valid);
endmodule

// File: tb/vstream_mend_bench.sv
`timescale 1ns/100ps
module vstream_mend_bench;
  localparam int DW = 24;
  localparam int CW = 12;
  localparam int LG = 2;
  localparam int FG = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic out_ready = 1'b1;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  vstream_mend #(.DW(DW), .CW(CW), .DEF_W(1920), .DEF_H(1080),
                 .LINE_GAP(LG), .FRAME_GAP(FG)) u_vstream_mend (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, acc_cnt = 0, hold_bad = 0;
  bit done = 1'b0, bp_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [DW-1:0] got_d[$], exp_d[$];
  logic got_s[$], got_e[$], exp_s[$], exp_e[$];
  int got_c[$];
  logic prev_stall = 1'b0;
  logic [DW+1:0] prev_beat = '0;

  always @(posedge clk) begin
    cyc++;
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) begin
        got_d.push_back(out_data); got_s.push_back(out_sop);
        got_e.push_back(out_eop);  got_c.push_back(cyc);
      end
      if (in_valid && in_ready) acc_cnt++;
      if (prev_stall && !(out_valid && {out_sop, out_eop, out_data} == prev_beat))
        hold_bad++;
      prev_stall = out_valid && !out_ready;
      prev_beat  = {out_sop, out_eop, out_data};
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic sync();
    @(posedge clk); #1;
  endtask

  task automatic clear_q();
    got_d.delete(); got_s.delete(); got_e.delete(); got_c.delete();
    exp_d.delete(); exp_s.delete(); exp_e.delete();
  endtask

  task automatic cfg_write(input logic a, input int v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CW'(v);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic send_beat(input logic [DW-1:0] d, input logic s, input logic e);
    bit ok = 1'b0;
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
    while (!ok) begin
      @(negedge clk);
      ok = in_ready;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  // header plus n payload beats; header carries eop when n is zero
  task automatic send_pkt(input logic [DW-1:0] hdr, input int n, input int base);
    send_beat(hdr, 1'b1, n == 0);
    for (int i = 0; i < n; i++) send_beat(DW'(base + i), 1'b0, i == n - 1);
  endtask

  task automatic exp_video(input logic [DW-1:0] hdr, input int n, input int base,
                           input int w, input int h);
    int wh = w * h;
    int m = (n < wh) ? n : wh;
    logic [DW-1:0] lastv = (n > 0) ? DW'(base + n - 1) : '0;
    exp_d.push_back(hdr); exp_s.push_back(1'b1); exp_e.push_back(1'b0);
    for (int i = 0; i < m; i++) begin
      exp_d.push_back(DW'(base + i)); exp_s.push_back(1'b0); exp_e.push_back(i == wh - 1);
    end
    for (int i = n; i < wh; i++) begin
      exp_d.push_back(lastv); exp_s.push_back(1'b0); exp_e.push_back(i == wh - 1);
    end
  endtask

  task automatic exp_raw(input logic [DW-1:0] hdr, input int n, input int base);
    exp_d.push_back(hdr); exp_s.push_back(1'b1); exp_e.push_back(n == 0);
    for (int i = 0; i < n; i++) begin
      exp_d.push_back(DW'(base + i)); exp_s.push_back(1'b0); exp_e.push_back(i == n - 1);
    end
  endtask

  task automatic drain();
    int w = 0;
    while (got_d.size() < exp_d.size() && w < 4000) begin
      @(posedge clk); w++;
    end
    repeat (40) @(posedge clk);
  endtask

  task automatic compare(input string tag);
    int n = (got_d.size() < exp_d.size()) ? got_d.size() : exp_d.size();
    chk(got_d.size() == exp_d.size(), tag, "beat count", got_d.size(), exp_d.size());
    for (int i = 0; i < n; i++)
      chk({got_s[i], got_e[i], got_d[i]} == {exp_s[i], exp_e[i], exp_d[i]}, tag,
          $sformatf("beat %0d {sop,eop,data}", i),
          {got_s[i], got_e[i], got_d[i]}, {exp_s[i], exp_e[i], exp_d[i]});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  // two exact frames back to back; checks sequence, line gap and frame gap
  task automatic t_exact_gaps();
    clear_q(); sync();
    exp_video(24'h00AB10, 8, 'h100, 4, 2);
    exp_video(24'h00CD20, 8, 'h200, 4, 2);
    send_pkt(24'h00AB10, 8, 'h100);
    send_pkt(24'h00CD20, 8, 'h200);
    drain();
    compare("R3");
    if (got_c.size() >= 10) begin
      chk(got_c[5] - got_c[4] == LG + 1, "R7", "line gap distance", got_c[5] - got_c[4], LG + 1);
      chk(got_c[9] - got_c[8] == FG + 1, "R8", "frame gap distance", got_c[9] - got_c[8], FG + 1);
      chk(got_c[1] - got_c[0] == 1, "R2", "header to first pixel", got_c[1] - got_c[0], 1);
    end else chk(1'b0, "R7", "too few beats for gap check", got_c.size(), 10);
  endtask

  task automatic t_short();
    clear_q(); sync();
    exp_video(24'h000010, 3, 'h300, 4, 2);
    send_pkt(24'h000010, 3, 'h300);
    @(negedge clk);
    chk(in_ready == 1'b0, "R4", "in_ready during padding", in_ready, 0);
    drain();
    compare("R4");
  endtask

  task automatic t_empty();
    clear_q(); sync();
    exp_video(24'h0A0000, 0, 0, 4, 2);
    send_pkt(24'h0A0001 & 24'hFFFFF0, 0, 0);
    drain();
    compare("R2");
  endtask

  task automatic t_long();
    int a0;
    clear_q(); sync();
    a0 = acc_cnt;
    exp_video(24'h005550, 12, 'h400, 4, 2);
    exp_raw(24'h000003, 2, 'h480);
    send_pkt(24'h005550, 12, 'h400);
    send_pkt(24'h000003, 2, 'h480);
    drain();
    compare("R5");
    chk(acc_cnt - a0 == 16, "R5", "beats accepted", acc_cnt - a0, 16);
  endtask

  task automatic t_nonvideo();
    clear_q(); sync();
    exp_raw(24'h123455, 5, 'h500);
    exp_raw(24'h00F00B, 0, 0);
    exp_raw(24'h00000F, 2, 'h600);
    send_pkt(24'h123455, 5, 'h500);
    send_pkt(24'h00F00B, 0, 0);
    send_pkt(24'h00000F, 2, 'h600);
    drain();
    compare("R6");
    if (got_c.size() >= 6)
      chk(got_c[5] - got_c[0] == 5, "R6", "user packet span", got_c[5] - got_c[0], 5);
  endtask

  task automatic t_stray();
    int a0;
    clear_q(); sync();
    a0 = acc_cnt;
    exp_raw(24'h000002, 2, 'h700);
    send_beat(24'h000777, 1'b0, 1'b0);
    send_beat(24'h000000, 1'b0, 1'b0);
    send_beat(24'h000779, 1'b0, 1'b1);
    send_pkt(24'h000002, 2, 'h700);
    drain();
    compare("R11");
    chk(acc_cnt - a0 == 6, "R11", "beats accepted", acc_cnt - a0, 6);
  endtask

  task automatic t_backpressure();
    clear_q(); sync();
    hold_bad = 0;
    bp_en = 1'b1;
    exp_video(24'h000000, 5, 'h800, 4, 2);
    exp_video(24'h000010, 8, 'h900, 4, 2);
    exp_raw(24'h000007, 3, 'hA00);
    send_pkt(24'h000000, 5, 'h800);
    send_pkt(24'h000010, 8, 'h900);
    send_pkt(24'h000007, 3, 'hA00);
    drain();
    bp_en = 1'b0;
    compare("R9");
    chk(hold_bad == 0, "R9", "stalled beats changed", hold_bad, 0);
  endtask

  task automatic t_cfg();
    clear_q(); sync();
    exp_video(24'h000B00, 8, 'hB00, 4, 2);
    fork
      send_pkt(24'h000B00, 8, 'hB00);
      begin repeat (3) @(posedge clk); cfg_write(1'b0, 2); end
    join
    exp_video(24'h000C00, 4, 'hC00, 2, 2);
    send_pkt(24'h000C00, 4, 'hC00);
    drain();
    compare("R10");
    clear_q();
    cfg_write(1'b0, 0); cfg_write(1'b1, 0);
    sync();
    exp_video(24'h000D00, 3, 'hD00, 1, 1);
    send_pkt(24'h000D00, 3, 'hD00);
    drain();
    compare("R10");
    cfg_write(1'b0, 4); cfg_write(1'b1, 2);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    t_reset();
    cfg_write(1'b0, 4);
    cfg_write(1'b1, 2);
    t_exact_gaps();
    t_short();
    t_empty();
    t_long();
    t_nonvideo();
    t_stray();
    t_backpressure();
    t_cfg();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule